// File: doc/BRIEF.md
# Reservation-Based Atomic Word Unit

This unit sits on the memory side of a shared word store and carries out single-word atomic operations on it. A requester sends commands as one or two 32-bit flits on a valid/ready command channel. Each flit carries an operation code and a word address. The unit returns one or two flits on a valid/ready response channel, and it serves one command at a time.

A linked load returns the word and a fresh 32-bit signature. The signature comes from a counter that advances by one on every linked load. The unit records the address and signature of each linked load in a small reservation table. A store-conditional must bring that signature back. It succeeds only while a live entry for the same address holds the same signature. Any plain write, successful store-conditional or successful compare-and-swap to an address removes every reservation on that address. When the table is full, the oldest slot is reused in round-robin order.

Top module: `atomic_word_unit`

## Requirements
- R1: After reset `cmdReady` is 1, `rspValid` is 0 and every memory word reads as 0.
- R2: Opcode 0 (read) returns the addressed word in one flit. Opcode 1 (write) stores `cmdData` and returns one flit of value 0. Opcodes 5 to 7 act as a read.
- R3: Opcode 2 (linked load) returns two flits: the word with `rspLast` 0, then the signature with `rspLast` 1. Every other opcode returns a single flit with `rspLast` 1.
- R4: The first signature after reset is 1, and each later linked load returns the previous signature plus one.
- R5: Opcode 3 (store-conditional) takes the new word in its first flit and the signature in its second. When a live reservation matches both the address and the signature, it writes the word and responds 0.
- R6: A store-conditional with no matching live reservation responds 1, leaves memory unchanged and leaves the existing reservations in place.
- R7: A successful store-conditional removes all reservations on its address.
- R8: A plain write removes the reservations on its address and leaves reservations on other addresses intact.
- R9: Opcode 4 (compare-and-swap) takes the expected value in its first flit and the new value in its second. When the word equals the expected value, it writes the new value and responds 0. Otherwise it responds 1 and does not write.
- R10: A successful compare-and-swap removes all reservations on its address.
- R11: The table holds `RES_ENTRIES` reservations. A linked load made while the table is full overwrites the oldest allocated slot, and the reservation in that slot is lost.
- R12: While a response is pending, `cmdReady` is 0. While `rspValid` is 1 and `rspReady` is 0, `rspValid`, `rspData` and `rspLast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command flit valid |
| cmdReady | output | 1 | Unit accepts a command flit |
| cmdOp | input | 3 | Operation code, taken from the first flit |
| cmdAddr | input | ADDR_W | Word address, taken from the first flit |
| cmdData | input | 32 | Flit payload |
| rspValid | output | 1 | Response flit valid |
| rspReady | input | 1 | Requester accepts the response flit |
| rspData | output | 32 | Response payload |
| rspLast | output | 1 | Last flit of the response |

## Verification
The bench builds the unit with `RES_ENTRIES` = 2 and the default 16-word memory. With only two slots, round-robin replacement and the loss of the oldest reservation (R11) show up after three linked loads. Tests that need two reservations at once, such as a write that must spare a neighbour, still fit in the table. The bench keeps its own expected signature count, so every linked load checks the exact sequence of signatures.

// File: rtl/atomic_word_pkg.sv
package atomic_word_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_LL    = 3'd2,
    OP_SC    = 3'd3,
    OP_CAS   = 3'd4
  } opCode_t;

  typedef struct packed {
    logic    capFirst;
    logic    capSecond;
    logic    exec;
    logic    selSecond;
    opCode_t op;
  } ctrlStrobe_t;
endpackage

// File: rtl/atomic_word_ctrl.sv
module atomic_word_ctrl
  import atomic_word_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic [2:0]  cmdOp,
  output logic        rspValid,
  input  logic        rspReady,
  output logic        rspLast,
  output ctrlStrobe_t strobe
);
  typedef enum logic [2:0] {S_IDLE, S_SECOND, S_EXEC, S_RSP0, S_RSP1} state_t;
  state_t  state, stateNext;
  opCode_t opReg, opIn;

  always_comb begin
    case (cmdOp)
      3'd1:    opIn = OP_WRITE;
      3'd2:    opIn = OP_LL;
      3'd3:    opIn = OP_SC;
      3'd4:    opIn = OP_CAS;
      default: opIn = OP_READ;
    endcase
  end

  assign cmdReady = (state == S_IDLE) || (state == S_SECOND);
  assign rspValid = (state == S_RSP0) || (state == S_RSP1);
  assign rspLast  = (state == S_RSP1) || ((state == S_RSP0) && (opReg != OP_LL));

  always_comb begin
    stateNext        = state;
    strobe.capFirst  = 1'b0;
    strobe.capSecond = 1'b0;
    strobe.exec      = 1'b0;
    strobe.selSecond = (state == S_RSP1);
    strobe.op        = opReg;
    case (state)
      S_IDLE: if (cmdValid) begin
        strobe.capFirst = 1'b1;
        stateNext = (opIn == OP_SC || opIn == OP_CAS) ? S_SECOND : S_EXEC;
      end
      S_SECOND: if (cmdValid) begin
        strobe.capSecond = 1'b1;
        stateNext = S_EXEC;
      end
      S_EXEC: begin
        strobe.exec = 1'b1;
        stateNext = S_RSP0;
      end
      S_RSP0: if (rspReady) stateNext = (opReg == OP_LL) ? S_RSP1 : S_IDLE;
      S_RSP1: if (rspReady) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= OP_READ;
    end else begin
      state <= stateNext;
      if (strobe.capFirst) opReg <= opIn;
    end
  end
endmodule

// File: rtl/atomic_word_dp.sv
module atomic_word_dp
  import atomic_word_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RES_ENTRIES = 4,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int PTR_W      = (RES_ENTRIES > 1) ? $clog2(RES_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdData,
  output logic [31:0]       rspData
);
  logic [31:0]       mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [31:0]       word0, word1, res0, res1, sigCount;
  logic [31:0]       curWord;
  logic              resValid [RES_ENTRIES];
  logic [ADDR_W-1:0] resAddr  [RES_ENTRIES];
  logic [31:0]       resSig   [RES_ENTRIES];
  logic [PTR_W-1:0]  allocPtr;
  logic [RES_ENTRIES-1:0] addrHit, sigHit;
  logic              scHit, clearAddr, doWrite;
  logic [31:0]       writeVal;

  assign curWord = mem[addrReg];

  for (genvar g = 0; g < RES_ENTRIES; g++) begin : g_match
    assign addrHit[g] = resValid[g] && (resAddr[g] == addrReg);
    assign sigHit[g]  = addrHit[g] && (resSig[g] == word1);
  end
  assign scHit = |sigHit;

  always_comb begin
    doWrite  = 1'b0;
    writeVal = word0;
    case (strobe.op)
      OP_WRITE: doWrite = 1'b1;
      OP_SC:    doWrite = scHit;
      OP_CAS: begin
        doWrite  = (curWord == word0);
        writeVal = word1;
      end
      default: doWrite = 1'b0;
    endcase
    clearAddr = strobe.exec && doWrite;
  end

  assign rspData = strobe.selSecond ? res1 : res0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < RES_ENTRIES; i++) begin
        resValid[i] <= 1'b0;
        resAddr[i]  <= '0;
        resSig[i]   <= '0;
      end
      addrReg  <= '0;
      word0    <= '0;
      word1    <= '0;
      res0     <= '0;
      res1     <= '0;
      sigCount <= 32'd1;
      allocPtr <= '0;
    end else begin
      if (strobe.capFirst) begin
        addrReg <= cmdAddr;
        word0   <= cmdData;
      end
      if (strobe.capSecond) word1 <= cmdData;
      if (strobe.exec) begin
        res0 <= (strobe.op == OP_READ || strobe.op == OP_LL) ? curWord :
                (strobe.op == OP_WRITE) ? 32'd0 : {31'd0, !doWrite};
        if (doWrite) mem[addrReg] <= writeVal;
        if (strobe.op == OP_LL) begin
          res1               <= sigCount;
          sigCount           <= sigCount + 32'd1;
          resValid[allocPtr] <= 1'b1;
          resAddr[allocPtr]  <= addrReg;
          resSig[allocPtr]   <= sigCount;
          allocPtr <= (allocPtr == PTR_W'(RES_ENTRIES - 1)) ? '0 : allocPtr + 1'b1;
        end
      end
      if (clearAddr)
        for (int i = 0; i < RES_ENTRIES; i++)
          if (addrHit[i]) resValid[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/atomic_word_unit.sv
module atomic_word_unit
  import atomic_word_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RES_ENTRIES = 4,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [31:0]       rspData,
  output logic              rspLast
);
  ctrlStrobe_t strobe;

  atomic_word_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .rspValid(rspValid), .rspReady(rspReady),
    .rspLast(rspLast), .strobe(strobe)
  );

  atomic_word_dp #(.DEPTH(DEPTH), .RES_ENTRIES(RES_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .rspData(rspData)
  );
endmodule

// File: rtl/atomic_word_checker.sv
module atomic_word_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic [31:0] rspData,
  input logic        rspLast
);
  // R12: a stalled response must not change
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspData) && $stable(rspLast));

  // R12: no command is taken while a response is pending
  assert_no_cmd_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !cmdReady);

  // R3: a non-final flit is followed by the final flit
  assert_second_flit_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady && !rspLast |=> rspValid && rspLast);

  // R3: after the last flit is taken, the response channel goes idle
  assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady && rspLast |=> !rspValid);

  // R1: the unit leaves reset ready for a command and with no response
  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> cmdReady && !rspValid);
endmodule

bind atomic_word_unit atomic_word_checker u_checker (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast)
);

// File: tb/atomic_word_unit_tb.sv
module atomic_word_unit_tb;
  localparam int DEPTH = 16;
  localparam int RES   = 2;

  logic        clk = 0, rstN = 0;
  logic        cmdValid = 0, rspReady = 0;
  logic        cmdReady, rspValid, rspLast;
  logic [2:0]  cmdOp = 0;
  logic [3:0]  cmdAddr = 0;
  logic [31:0] cmdData = 0, rspData;
  int          nChecks = 0, nFails = 0;
  logic [31:0] nextSig = 32'd1;
  logic        done = 0;

  always #10 clk = ~clk;

  atomic_word_unit #(.DEPTH(DEPTH), .RES_ENTRIES(RES)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendFlit(logic [2:0] op, logic [3:0] addr, logic [31:0] data);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdAddr = addr; cmdData = data;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic getFlit(output logic [31:0] data, output logic last);
    rspReady = 1;
    while (!rspValid) @(negedge clk);
    data = rspData; last = rspLast;
    @(negedge clk);
    rspReady = 0;
  endtask

  task automatic single(string req, logic [2:0] op, logic [3:0] addr,
                        logic [31:0] d0, logic [31:0] d1, logic [31:0] exp);
    logic [31:0] r; logic l;
    sendFlit(op, addr, d0);
    if (op == 3 || op == 4) sendFlit(op, addr, d1);
    getFlit(r, l);
    check(req, r, exp);
    check({req, " last"}, {31'd0, l}, 32'd1);
  endtask

  task automatic linkedLoad(logic [3:0] addr, logic [31:0] expWord, output logic [31:0] sig);
    logic [31:0] r; logic l;
    sendFlit(3'd2, addr, 0);
    getFlit(r, l);
    check("R3 ll word", r, expWord);
    check("R3 ll first not last", {31'd0, l}, 32'd0);
    getFlit(r, l);
    check("R4 ll signature", r, nextSig);
    check("R3 ll second last", {31'd0, l}, 32'd1);
    sig = r;
    nextSig++;
  endtask

  task automatic tReset();
    check("R1 cmdReady", {31'd0, cmdReady}, 32'd1);
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    single("R1 mem zero", 3'd0, 4'd3, 0, 0, 32'd0);
  endtask

  task automatic tReadWrite();
    single("R2 write ack", 3'd1, 4'd5, 32'hA5, 0, 32'd0);
    single("R2 read back", 3'd0, 4'd5, 0, 0, 32'hA5);
    single("R2 op7 reads", 3'd7, 4'd5, 0, 0, 32'hA5);
  endtask

  task automatic tScPass();
    logic [31:0] s;
    linkedLoad(4'd5, 32'hA5, s);
    single("R5 sc ok", 3'd3, 4'd5, 32'h11, s, 32'd0);
    single("R5 sc stored", 3'd0, 4'd5, 0, 0, 32'h11);
    single("R7 sc reuse fails", 3'd3, 4'd5, 32'h22, s, 32'd1);
    single("R7 mem kept", 3'd0, 4'd5, 0, 0, 32'h11);
  endtask

  task automatic tScFail();
    logic [31:0] s;
    linkedLoad(4'd7, 32'd0, s);
    single("R6 bad sig", 3'd3, 4'd7, 32'h33, s + 32'd99, 32'd1);
    single("R6 mem unchanged", 3'd0, 4'd7, 0, 0, 32'd0);
    single("R6 other addr", 3'd3, 4'd6, 32'h33, s, 32'd1);
    single("R6 reservation kept", 3'd3, 4'd7, 32'h44, s, 32'd0);
  endtask

  task automatic tWriteClears();
    logic [31:0] sa, sb;
    linkedLoad(4'd8, 32'd0, sa);
    linkedLoad(4'd9, 32'd0, sb);
    single("R8 write", 3'd1, 4'd8, 32'h55, 0, 32'd0);
    single("R8 sc after write fails", 3'd3, 4'd8, 32'h66, sa, 32'd1);
    single("R8 neighbour kept", 3'd3, 4'd9, 32'h77, sb, 32'd0);
  endtask

  task automatic tCas();
    logic [31:0] s;
    single("R9 setup", 3'd1, 4'd10, 32'd7, 0, 32'd0);
    single("R9 cas miss", 3'd4, 4'd10, 32'd8, 32'd9, 32'd1);
    single("R9 no write", 3'd0, 4'd10, 0, 0, 32'd7);
    single("R9 cas hit", 3'd4, 4'd10, 32'd7, 32'd9, 32'd0);
    single("R9 written", 3'd0, 4'd10, 0, 0, 32'd9);
    linkedLoad(4'd10, 32'd9, s);
    single("R10 cas hit", 3'd4, 4'd10, 32'd9, 32'd4, 32'd0);
    single("R10 sc after cas fails", 3'd3, 4'd10, 32'd5, s, 32'd1);
    single("R10 value kept", 3'd0, 4'd10, 0, 0, 32'd4);
  endtask

  task automatic tEvict();
    logic [31:0] sx, sy, sz;
    linkedLoad(4'd11, 32'd0, sx);
    linkedLoad(4'd12, 32'd0, sy);
    linkedLoad(4'd13, 32'd0, sz);
    single("R11 evicted fails", 3'd3, 4'd11, 32'd1, sx, 32'd1);
    single("R11 newest ok", 3'd3, 4'd13, 32'd2, sz, 32'd0);
    single("R11 middle ok", 3'd3, 4'd12, 32'd3, sy, 32'd0);
  endtask

  task automatic tStall();
    logic [31:0] held, r; logic l;
    sendFlit(3'd0, 4'd13, 0);
    while (!rspValid) @(negedge clk);
    held = rspData;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R12 valid held", {31'd0, rspValid}, 32'd1);
      check("R12 data held", rspData, held);
      check("R12 cmd blocked", {31'd0, cmdReady}, 32'd0);
    end
    getFlit(r, l);
    check("R12 stalled data", r, 32'd2);
    check("R12 ready again", {31'd0, cmdReady}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tReadWrite();
    tScPass();
    tScFail();
    tWriteClears();
    tCas();
    tEvict();
    tStall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule